// File: doc/BRIEF.md
# Partitioned Static Memory with One-Hot Sub-Block Enable

This block is a single-port word memory split into many equal sub-blocks. Each access touches exactly one sub-block, so the others stay idle. A request consists of a read strobe, a write strobe, a flat word address and write data, and it is sampled into an input register on a rising clock edge. The upper address bits go through a full decoder that produces a one-hot sub-block enable. The middle bits pick a physical row. The lowest bits pick one of the words packed side by side on that row.

Inside a sub-block, rows are not selected by one wide decoder. An access pulse is first gated by the sub-block enable. It is then split into a few row groups, and each row group is combined with a smaller row decode. The result is that a sub-block that is not enabled sees no wordline and no column activity.

The default configuration is reduced so that it simulates quickly. It has 32 sub-blocks of 16 rows, with four 32-bit words on each row. The full-size arrangement, 32 sub-blocks of 256 rows by 128 columns, is reached by setting the row parameter. The port `blkActive` shows, on each cycle, which sub-block is working on the captured request.

Top module: `banked_sram`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `rdData` is zero and `blkActive` is all zero.
- R2: A word read from an address returns the last data written to that same address. The address fields are: sub-block index in the top bits, row in the middle bits, word-in-row in the two lowest bits.
- R3: After a rising edge that captures a read or a write, `blkActive` has exactly one bit set, at the index given by the sub-block field of the captured address, until the next edge.
- R4: After a rising edge that captures neither read nor write, `blkActive` is all zero.
- R5: For a read captured at rising edge k, `rdData` shows the word at rising edge k+1.
- R6: `rdData` keeps its value on every edge where no read-only access is performed.
- R7: When read and write are both asserted, the write is performed and `rdData` is left unchanged.
- R8: Writing one word of a row leaves the other words on that row unchanged.
- R9: Equal row and word fields in different sub-blocks address separate storage.
- R10: Reads issued on consecutive cycles each return their own word, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdIn | input | 1 | Read strobe |
| wrIn | input | 1 | Write strobe (wins over read) |
| addrIn | input | ADDR_W (11) | Flat word address {sub-block, row, word} |
| wrDataIn | input | WORD_W (32) | Write data |
| rdData | output | WORD_W (32) | Registered read data |
| blkActive | output | NUM_BLOCKS (32) | One-hot sub-block active indicator |

## Verification
The bench targets words that share a row. A wrong column mask there would overwrite a neighbour. It also targets the same row and word in the lowest and highest sub-blocks, where a bad block decode would alias the two. A design that let the read win on a combined read and write would return stale data and leave the memory unwritten, and a missing hold would let `rdData` drift on idle cycles. Back-to-back reads expose a design with one register too many or too few in the read path, and idle cycles expose an enable that is not cleared.

// File: rtl/banked_sram_pkg.sv
package banked_sram_pkg;
  // Strobes that the control hands to the datapath for the captured request.
  typedef struct packed {
    logic pulse;    // any access this cycle
    logic doWrite;  // write to the selected word
    logic doRead;   // read-only access (write wins)
  } sramStrobe_t;
endpackage

// File: rtl/banked_sram_ctrl.sv
module banked_sram_ctrl
  import banked_sram_pkg::*;
#(
  parameter int NUM_BLOCKS    = 32,
  parameter int ROWS          = 16,
  parameter int GATE_BITS     = 2,
  parameter int WORDS_PER_ROW = 4,
  parameter int WORD_W        = 32,
  localparam int BLK_BITS  = $clog2(NUM_BLOCKS),
  localparam int ROW_BITS  = $clog2(ROWS),
  localparam int WSEL_BITS = $clog2(WORDS_PER_ROW),
  localparam int DEC_BITS  = ROW_BITS - GATE_BITS,
  localparam int GROUPS    = 1 << GATE_BITS,
  localparam int DEC_ROWS  = 1 << DEC_BITS,
  localparam int ADDR_W    = BLK_BITS + ROW_BITS + WSEL_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rdIn,
  input  logic                  wrIn,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [WORD_W-1:0]     wrDataIn,
  output sramStrobe_t           strobe,
  output logic [NUM_BLOCKS-1:0] blkEn,
  output logic [GROUPS-1:0]     rowGate,
  output logic [DEC_ROWS-1:0]   rowDec,
  output logic [WSEL_BITS-1:0]  wordIdx,
  output logic [WORD_W-1:0]     wrData
);

  // Input register
  logic              rdQ, wrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdQ   <= 1'b0;
      wrQ   <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      rdQ   <= rdIn;
      wrQ   <= wrIn;
      addrQ <= addrIn;
      dataQ <= wrDataIn;
    end
  end

  // Address fields
  logic [BLK_BITS-1:0]  blkField;
  logic [GATE_BITS-1:0] gateField;
  logic [DEC_BITS-1:0]  decField;

  assign blkField  = addrQ[ADDR_W-1 -: BLK_BITS];
  assign gateField = addrQ[WSEL_BITS+ROW_BITS-1 -: GATE_BITS];
  assign decField  = addrQ[WSEL_BITS +: DEC_BITS];
  assign wordIdx   = addrQ[WSEL_BITS-1:0];
  assign wrData    = dataQ;

  always_comb begin
    strobe.pulse   = rdQ | wrQ;
    strobe.doWrite = wrQ;
    strobe.doRead  = rdQ & ~wrQ;
  end

  // Full block decoder, qualified by the access pulse
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blkDec
    assign blkEn[b] = strobe.pulse && (blkField == BLK_BITS'(b));
  end

  // Row group select (second gating level)
  for (genvar g = 0; g < GROUPS; g++) begin : g_gateDec
    assign rowGate[g] = (gateField == GATE_BITS'(g));
  end

  // Reduced row decode inside a group
  for (genvar d = 0; d < DEC_ROWS; d++) begin : g_rowDec
    assign rowDec[d] = (decField == DEC_BITS'(d));
  end

endmodule

// File: rtl/banked_sram_subblk.sv
module banked_sram_subblk
  import banked_sram_pkg::*;
#(
  parameter int ROWS          = 16,
  parameter int GATE_BITS     = 2,
  parameter int WORDS_PER_ROW = 4,
  parameter int WORD_W        = 32,
  localparam int ROW_BITS  = $clog2(ROWS),
  localparam int WSEL_BITS = $clog2(WORDS_PER_ROW),
  localparam int DEC_BITS  = ROW_BITS - GATE_BITS,
  localparam int GROUPS    = 1 << GATE_BITS,
  localparam int DEC_ROWS  = 1 << DEC_BITS,
  localparam int ROW_W     = WORDS_PER_ROW * WORD_W
) (
  input  logic                 clk,
  input  logic                 blkEn,
  input  sramStrobe_t          strobe,
  input  logic [GROUPS-1:0]    rowGate,
  input  logic [DEC_ROWS-1:0]  rowDec,
  input  logic [WSEL_BITS-1:0] wordIdx,
  input  logic [WORD_W-1:0]    wrData,
  output logic [WORD_W-1:0]    rdWord
);

  // Level 1: pulse gated by the sub-block enable
  logic lvl1Pulse;
  assign lvl1Pulse = strobe.pulse & blkEn;

  // Level 2: split into row groups
  logic [GROUPS-1:0] lvl2Pulse;
  for (genvar g = 0; g < GROUPS; g++) begin : g_lvl2
    assign lvl2Pulse[g] = lvl1Pulse & rowGate[g];
  end

  // Wordlines: group pulse combined with the reduced decode
  logic [ROWS-1:0] wordLine;
  for (genvar g = 0; g < GROUPS; g++) begin : g_wlGrp
    for (genvar d = 0; d < DEC_ROWS; d++) begin : g_wlRow
      assign wordLine[g*DEC_ROWS + d] = lvl2Pulse[g] & rowDec[d];
    end
  end

  logic [ROW_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (strobe.doWrite) begin
      for (int r = 0; r < ROWS; r++) begin
        if (wordLine[r]) cells[r][int'(wordIdx)*WORD_W +: WORD_W] <= wrData;
      end
    end
  end

  logic [ROW_W-1:0] rowBits;
  always_comb begin
    rowBits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wordLine[r]) rowBits = rowBits | cells[r];
    end
    rdWord = strobe.doRead ? rowBits[int'(wordIdx)*WORD_W +: WORD_W] : '0;
  end

endmodule

// File: rtl/banked_sram_dp.sv
module banked_sram_dp
  import banked_sram_pkg::*;
#(
  parameter int NUM_BLOCKS    = 32,
  parameter int ROWS          = 16,
  parameter int GATE_BITS     = 2,
  parameter int WORDS_PER_ROW = 4,
  parameter int WORD_W        = 32,
  localparam int ROW_BITS  = $clog2(ROWS),
  localparam int WSEL_BITS = $clog2(WORDS_PER_ROW),
  localparam int DEC_BITS  = ROW_BITS - GATE_BITS,
  localparam int GROUPS    = 1 << GATE_BITS,
  localparam int DEC_ROWS  = 1 << DEC_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sramStrobe_t           strobe,
  input  logic [NUM_BLOCKS-1:0] blkEn,
  input  logic [GROUPS-1:0]     rowGate,
  input  logic [DEC_ROWS-1:0]   rowDec,
  input  logic [WSEL_BITS-1:0]  wordIdx,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData
);

  logic [WORD_W-1:0] blkWord [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    banked_sram_subblk #(
      .ROWS(ROWS), .GATE_BITS(GATE_BITS),
      .WORDS_PER_ROW(WORDS_PER_ROW), .WORD_W(WORD_W)
    ) subBlk_i (
      .clk(clk), .blkEn(blkEn[b]), .strobe(strobe),
      .rowGate(rowGate), .rowDec(rowDec), .wordIdx(wordIdx),
      .wrData(wrData), .rdWord(blkWord[b])
    );
  end

  // Idle sub-blocks drive zero, so a plain OR merges them
  logic [WORD_W-1:0] mergedWord;
  always_comb begin
    mergedWord = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) mergedWord = mergedWord | blkWord[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdData <= '0;
    else if (strobe.doRead) rdData <= mergedWord;
  end

endmodule

// File: rtl/banked_sram.sv
module banked_sram
  import banked_sram_pkg::*;
#(
  parameter int NUM_BLOCKS    = 32,
  parameter int ROWS          = 16,
  parameter int GATE_BITS     = 2,
  parameter int WORDS_PER_ROW = 4,
  parameter int WORD_W        = 32,
  localparam int BLK_BITS  = $clog2(NUM_BLOCKS),
  localparam int ROW_BITS  = $clog2(ROWS),
  localparam int WSEL_BITS = $clog2(WORDS_PER_ROW),
  localparam int DEC_BITS  = ROW_BITS - GATE_BITS,
  localparam int GROUPS    = 1 << GATE_BITS,
  localparam int DEC_ROWS  = 1 << DEC_BITS,
  localparam int ADDR_W    = BLK_BITS + ROW_BITS + WSEL_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rdIn,
  input  logic                  wrIn,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [WORD_W-1:0]     wrDataIn,
  output logic [WORD_W-1:0]     rdData,
  output logic [NUM_BLOCKS-1:0] blkActive
);

  sramStrobe_t          strobe;
  logic [NUM_BLOCKS-1:0] blkEn;
  logic [GROUPS-1:0]     rowGate;
  logic [DEC_ROWS-1:0]   rowDec;
  logic [WSEL_BITS-1:0]  wordIdx;
  logic [WORD_W-1:0]     wrData;

  banked_sram_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .ROWS(ROWS), .GATE_BITS(GATE_BITS),
    .WORDS_PER_ROW(WORDS_PER_ROW), .WORD_W(WORD_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rdIn(rdIn), .wrIn(wrIn),
    .addrIn(addrIn), .wrDataIn(wrDataIn), .strobe(strobe),
    .blkEn(blkEn), .rowGate(rowGate), .rowDec(rowDec),
    .wordIdx(wordIdx), .wrData(wrData)
  );

  banked_sram_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .ROWS(ROWS), .GATE_BITS(GATE_BITS),
    .WORDS_PER_ROW(WORDS_PER_ROW), .WORD_W(WORD_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .blkEn(blkEn),
    .rowGate(rowGate), .rowDec(rowDec), .wordIdx(wordIdx),
    .wrData(wrData), .rdData(rdData)
  );

  assign blkActive = blkEn;

endmodule

// File: rtl/banked_sram_chk.sv
module banked_sram_chk #(
  parameter int NUM_BLOCKS = 32,
  parameter int ADDR_W     = 11,
  parameter int WORD_W     = 32,
  localparam int BLK_BITS  = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rdIn,
  input logic                  wrIn,
  input logic [ADDR_W-1:0]     addrIn,
  input logic [WORD_W-1:0]     rdData,
  input logic [NUM_BLOCKS-1:0] blkActive
);
  localparam logic [NUM_BLOCKS-1:0] ONE = 1;

  // R3: never more than one sub-block active
  a_r3_single_block: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blkActive));

  // R3: the active sub-block is the addressed one
  a_r3_block_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIn || wrIn) |=> (blkActive == (ONE << $past(addrIn[ADDR_W-1 -: BLK_BITS]))));

  // R4: no activity after an idle capture
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdIn && !wrIn) |=> (blkActive == '0));

  // R7: combined read and write leaves read data alone
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIn && wrIn) |=> ##1 $stable(rdData));

  // R6: no read request, no change of read data
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdIn) |=> ##1 $stable(rdData));

endmodule

bind banked_sram banked_sram_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rdIn(rdIn), .wrIn(wrIn),
  .addrIn(addrIn), .rdData(rdData), .blkActive(blkActive)
);

// File: tb/banked_sram_tb_top.sv
module banked_sram_tb_top;
  localparam int NBLK   = 32;
  localparam int NROW   = 16;
  localparam int NWPR   = 4;
  localparam int WW     = 32;
  localparam int AW     = 11;
  localparam int NWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rdIn = 1'b0, wrIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [WW-1:0] wrDataIn = '0;
  logic [WW-1:0] rdData;
  logic [NBLK-1:0] blkActive;

  always #10 clk = ~clk;  // 50 MHz

  banked_sram #(.NUM_BLOCKS(NBLK), .ROWS(NROW), .GATE_BITS(2),
                .WORDS_PER_ROW(NWPR), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rdIn(rdIn), .wrIn(wrIn), .addrIn(addrIn),
    .wrDataIn(wrDataIn), .rdData(rdData), .blkActive(blkActive)
  );

  int testCnt = 0, failCnt = 0;
  bit done = 0;
  logic [WW-1:0] refMem [NWORDS];
  logic [WW-1:0] expRd = '0;

  function automatic logic [WW-1:0] pattern(input int a, input int salt);
    return WW'(32'h9E37_79B9 * (a + 1)) ^ WW'(salt * 32'h0101_0101);
  endfunction

  function automatic logic [NBLK-1:0] blkMask(input logic [AW-1:0] a);
    logic [NBLK-1:0] m = '0;
    m[a[AW-1 -: 5]] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: capture edge, array edge, then check outputs
  task automatic doOp(input bit rd, input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    rdIn = rd; wrIn = wr; addrIn = a; wrDataIn = d;
    @(negedge clk);
    if (rd || wr) check("R3 active block", 64'(blkActive), 64'(blkMask(a)));
    else          check("R4 idle block",   64'(blkActive), 64'(0));
    rdIn = 0; wrIn = 0;
    @(negedge clk);
    if (wr) refMem[a] = d;
    else if (rd) expRd = refMem[a];
    if (rd && wr)     check("R7 write wins, read data held", 64'(rdData), 64'(expRd));
    else if (rd)      check("R5/R2 read data", 64'(rdData), 64'(expRd));
    else              check("R6 read data held", 64'(rdData), 64'(expRd));
    check("R4 idle after access", 64'(blkActive), 64'(0));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset rdData", 64'(rdData), 64'(0));
    check("R1 reset blkActive", 64'(blkActive), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release rdData", 64'(rdData), 64'(0));
    check("R1 after release blkActive", 64'(blkActive), 64'(0));

    // Fill every word (R2)
    for (int a = 0; a < NWORDS; a++) doOp(0, 1, AW'(a), pattern(a, 1));

    // R8: words of one row independent
    for (int w = 0; w < NWPR; w++) doOp(0, 1, AW'(12'h0A4 + w), pattern(w, 7));
    doOp(0, 1, AW'(12'h0A6), 32'hDEAD_BEEF);
    for (int w = 0; w < NWPR; w++) doOp(1, 0, AW'(12'h0A4 + w), '0);
    check("R8 neighbour word kept", 64'(refMem[AW'(12'h0A5)]), 64'(pattern(1, 7)));

    // R9: same row and word in lowest and highest sub-block
    doOp(0, 1, {5'd0,  4'd9, 2'd3}, 32'h1111_0000);
    doOp(0, 1, {5'd31, 4'd9, 2'd3}, 32'h2222_FFFF);
    doOp(1, 0, {5'd0,  4'd9, 2'd3}, '0);
    check("R9 block 0 separate", 64'(rdData), 64'(32'h1111_0000));
    doOp(1, 0, {5'd31, 4'd9, 2'd3}, '0);
    check("R9 block 31 separate", 64'(rdData), 64'(32'h2222_FFFF));

    // R7: combined request, then confirm write happened
    doOp(1, 0, AW'(5), '0);
    doOp(1, 1, AW'(5), 32'hCAFE_F00D);
    doOp(1, 0, AW'(5), '0);
    check("R7 combined write stored", 64'(rdData), 64'(32'hCAFE_F00D));

    // R10: back-to-back reads
    begin
      logic [AW-1:0] pa [4];
      pa[0] = AW'(3); pa[1] = AW'(700); pa[2] = AW'(2047); pa[3] = AW'(1024);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (i >= 2) check("R10 pipelined read", 64'(rdData), 64'(refMem[pa[i-2]]));
        if (i < 4) begin rdIn = 1; wrIn = 0; addrIn = pa[i]; end
        else       begin rdIn = 0; end
      end
      expRd = refMem[pa[3]];
    end

    // Constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [AW-1:0] a = AW'($urandom_range(0, NWORDS-1));
      logic [WW-1:0] d = $urandom();
      if (sel < 4)      doOp(1, 0, a, d);
      else if (sel < 8) doOp(0, 1, a, d);
      else if (sel < 9) doOp(1, 1, a, d);
      else              doOp(0, 0, a, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule